// File: doc/BRIEF.md
# Partial-Region Freeze Bridge Controller

This block sits between the system bus and one reconfigurable region of the fabric. It keeps that region cut off from the bus while the region is being rewritten. Software drives it through four 32-bit registers: status, control, illegal-request capture and a constant version word. To isolate the region, software requests a freeze. The block then stops taking new requests on its valid/ready path and waits until every request it has already passed to the region has completed. Only then does it report the freeze as done. While isolated, software may hold the region in reset. It then requests an unfreeze, which releases the reset and opens the path again.

The block keeps count of requests in flight: a request is counted when it is handed to the region and uncounted on the region's completion pulse. A request arriving while the region is isolated is completed at once with an error and never reaches the region. Control writes that make no sense are not acted on and are recorded in the capture register. Writing a value with bit 0 set to that register clears it.

Top module: `frz_bridge_ctl`

## Requirements
- R1: A read at byte offset 12 returns the constant 2.
- R2: After reset, status reads 2 (unfreeze-done only), control reads 0, the capture register reads 0, and region_freeze and region_reset are low.
- R3: A control write of exactly 1 (freeze, bit 0) while running drops up_ready and dn_valid from the next cycle. Status bit 0 (freeze-done) is set only once the in-flight count is zero, one cycle after the drain state is entered at the earliest.
- R4: The in-flight count rises on each accepted handshake and falls on each dn_done pulse. It never exceeds MAX_INFLIGHT, and up_ready is low while the count is at that limit.
- R5: Status bit 0 (freeze-done) and bit 1 (unfreeze-done) are never both set. During draining both read 0.
- R6: While frozen, a request on up_valid is answered in the same cycle with up_ready and up_err high, and dn_valid stays low. The refusal sets bit 1 of the capture register (offset 8).
- R7: region_reset equals control bit 1 while frozen and is low otherwise.
- R8: A control write of exactly 4 (unfreeze, bit 2) while frozen returns the block to running on the next edge. Status then reads 2, region_freeze and region_reset go low, and traffic passes again.
- R9: A control write with more than one of bits 0..2 set, or with bit 2 while not frozen, sets capture bit 0. It leaves control and the bridge state unchanged.
- R10: A write to offset 8 with bit 0 set clears the capture register. A refusal or illegal write in the same cycle still sets its bit.
- R11: While running and below the limit, dn_valid follows up_valid, up_ready follows dn_ready, and up_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| up_valid | input | 1 | Bus-side request valid |
| up_ready | output | 1 | Bus-side request accepted or refused |
| up_err | output | 1 | Request refused with error |
| dn_valid | output | 1 | Request valid toward the region |
| dn_ready | input | 1 | Region ready to take a request |
| dn_done | input | 1 | Region completed one request |
| region_freeze | output | 1 | Region is isolated or draining |
| region_reset | output | 1 | Reset toward the isolated region |

## Verification
The assertions assume the region never pulses dn_done with nothing in flight, and that the register address is word aligned. The stimulus pulses dn_done only as many times as the bench has seen handshakes complete, and it uses only offsets 0, 4, 8 and 12. Inputs change only on the falling clock edge, so request, completion and register-write timing is never ambiguous at the rising edge.

// File: rtl/frz_pkg.sv
package frz_pkg;
  typedef enum logic [1:0] {
    FZ_RUN   = 2'd0,
    FZ_DRAIN = 2'd1,
    FZ_HOLD  = 2'd2
  } fz_state_t;

  localparam logic [1:0] IDX_STAT = 2'd0;
  localparam logic [1:0] IDX_CTRL = 2'd1;
  localparam logic [1:0] IDX_ILL  = 2'd2;
  localparam logic [1:0] IDX_VER  = 2'd3;

  localparam int CB_FREEZE   = 0;
  localparam int CB_RESET    = 1;
  localparam int CB_UNFREEZE = 2;
  localparam int CTRL_W      = 3;

  localparam int IB_CTRL   = 0;
  localparam int IB_REFUSE = 1;
  localparam int ILL_W     = 2;

  localparam logic [31:0] VERSION_WORD = 32'd2;
endpackage

// File: rtl/frz_seq.sv
module frz_seq
  import frz_pkg::*;
#(
  parameter int MAX_INFLIGHT = 4,
  localparam int CNT_W = $clog2(MAX_INFLIGHT + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      freeze_go,
  input  logic      unfreeze_go,
  input  logic      accept,
  input  logic      retire,
  output fz_state_t state_o,
  output logic      full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_INFLIGHT);

  fz_state_t        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      FZ_RUN:   if (freeze_go) st_n = FZ_DRAIN;
      FZ_DRAIN: if (cnt_q == '0) st_n = FZ_HOLD;
      FZ_HOLD:  if (unfreeze_go) st_n = FZ_RUN;
      default:  st_n = FZ_RUN;
    endcase
  end

  assign cnt_en = accept ^ retire;

  always_comb begin
    cnt_n = cnt_q;
    if (accept && !retire)      cnt_n = cnt_q + 1'b1;
    else if (retire && !accept) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FZ_RUN;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign state_o = st_q;
  assign full_o  = (cnt_q == CNT_MAX);

  // R4: count never passes the limit
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // R4: input assumption, no completion without a request in flight
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> cnt_q != '0);
  // R3: freeze-done is not reached while requests remain
  a_r3_drain_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FZ_DRAIN && cnt_q != '0) |=> st_q != FZ_HOLD);
  // R5: draining never jumps straight back to running
  a_r5_drain_not_run: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == FZ_DRAIN |=> st_q != FZ_RUN);
  // R8: an accepted unfreeze reopens the bridge on the next edge
  a_r8_unfreeze_runs: assert property (@(posedge clk) disable iff (!rst_n)
    unfreeze_go |=> st_q == FZ_RUN);
endmodule

// File: rtl/frz_gate.sv
module frz_gate
  import frz_pkg::*;
(
  input  fz_state_t state,
  input  logic      full,
  input  logic      up_valid,
  input  logic      dn_ready,
  output logic      dn_valid,
  output logic      up_ready,
  output logic      up_err,
  output logic      accept,
  output logic      refuse
);
  logic open_path;

  assign open_path = (state == FZ_RUN) && !full;

  always_comb begin
    dn_valid = 1'b0;
    up_ready = 1'b0;
    up_err   = 1'b0;
    if (open_path) begin
      dn_valid = up_valid;
      up_ready = dn_ready;
    end else if (state == FZ_HOLD) begin
      up_ready = up_valid;
      up_err   = up_valid;
    end
  end

  assign accept = open_path && up_valid && dn_ready;
  assign refuse = (state == FZ_HOLD) && up_valid;
endmodule

// File: rtl/frz_bridge_ctl.sv
module frz_bridge_ctl
  import frz_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 4,
  parameter int MAX_INFLIGHT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              up_valid,
  output logic              up_ready,
  output logic              up_err,
  output logic              dn_valid,
  input  logic              dn_ready,
  input  logic              dn_done,
  output logic              region_freeze,
  output logic              region_reset
);
  fz_state_t         state;
  logic              full, accept, refuse;
  logic [1:0]        widx;
  logic              wr_ctrl, wr_ill, bad_ctrl, freeze_go, unfreeze_go;
  logic [CTRL_W-1:0] wbits, ctrl_q, ctrl_n;
  logic              ctrl_en;
  logic [ILL_W-1:0]  ill_q, ill_n;
  logic              unused_bits;

  assign widx        = reg_addr[3:2];
  assign wbits       = reg_wdata[CTRL_W-1:0];
  assign unused_bits = ^{reg_wdata[DATA_W-1:CTRL_W], reg_addr[1:0]};

  assign wr_ctrl  = reg_wr && (widx == IDX_CTRL);
  assign wr_ill   = reg_wr && (widx == IDX_ILL);
  assign bad_ctrl = wr_ctrl && (($countones(wbits) > 1) ||
                    (wbits[CB_UNFREEZE] && state != FZ_HOLD));
  assign freeze_go   = wr_ctrl && !bad_ctrl && (wbits == CTRL_W'(1 << CB_FREEZE))
                       && state == FZ_RUN;
  assign unfreeze_go = wr_ctrl && !bad_ctrl && wbits[CB_UNFREEZE];

  frz_seq #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_seq (
    .clk, .rst_n, .freeze_go, .unfreeze_go,
    .accept, .retire(dn_done), .state_o(state), .full_o(full)
  );

  frz_gate u_gate (
    .state, .full, .up_valid, .dn_ready,
    .dn_valid, .up_ready, .up_err, .accept, .refuse
  );

  assign ctrl_en = wr_ctrl && !bad_ctrl;
  assign ctrl_n  = wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_n;
  end

  always_comb begin
    ill_n = ill_q;
    if (wr_ill && reg_wdata[0]) ill_n = '0;
    if (bad_ctrl) ill_n[IB_CTRL]   = 1'b1;
    if (refuse)   ill_n[IB_REFUSE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ill_q <= '0;
    else        ill_q <= ill_n;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (widx)
      IDX_STAT: reg_rdata = DATA_W'({state == FZ_RUN, state == FZ_HOLD});
      IDX_CTRL: reg_rdata = DATA_W'(ctrl_q);
      IDX_ILL:  reg_rdata = DATA_W'(ill_q);
      default:  reg_rdata = DATA_W'(VERSION_WORD);
    endcase
  end

  assign region_freeze = (state != FZ_RUN);
  assign region_reset  = ctrl_q[CB_RESET] && (state == FZ_HOLD);

  // R7: region reset only while isolated
  a_r7_reset_only_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    region_reset |-> region_freeze);
  // R3: nothing reaches the region while it is draining or frozen
  a_r3_no_traffic_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    region_freeze |-> !dn_valid);
  // R9: a rejected control write leaves control untouched
  a_r9_bad_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ctrl |=> $stable(ctrl_q));
  // R6: a refused request always sets its capture bit
  a_r6_refuse_logged: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> ill_q[IB_REFUSE]);
  // R8: the region is out of reset right after unfreeze
  a_r8_reset_released: assert property (@(posedge clk) disable iff (!rst_n)
    unfreeze_go |=> !region_reset && !region_freeze);
endmodule

// File: tb/frz_bridge_ctl_test.sv
module frz_bridge_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        up_valid, up_ready, up_err, dn_valid, dn_ready, dn_done;
  logic        region_freeze, region_reset;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  frz_bridge_ctl uut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .up_valid, .up_ready, .up_err, .dn_valid, .dn_ready, .dn_done,
    .region_freeze, .region_reset
  );

  // {write, waddr, wdata, raddr, expected read, requirement number}
  localparam logic [20:0] VEC [12] = '{
    {1'b0, 4'd0, 4'd0, 4'd12, 4'd2, 4'd1},  // R1 version
    {1'b0, 4'd0, 4'd0, 4'd0,  4'd2, 4'd2},  // R2 status after reset
    {1'b1, 4'd4, 4'd3, 4'd8,  4'd1, 4'd9},  // R9 two bits at once
    {1'b1, 4'd8, 4'd1, 4'd8,  4'd0, 4'd10}, // R10 clear capture
    {1'b1, 4'd4, 4'd4, 4'd8,  4'd1, 4'd9},  // R9 unfreeze while running
    {1'b1, 4'd8, 4'd1, 4'd4,  4'd0, 4'd9},  // R9 control unchanged
    {1'b1, 4'd4, 4'd1, 4'd0,  4'd1, 4'd3},  // R3 freeze with nothing in flight
    {1'b1, 4'd4, 4'd2, 4'd4,  4'd2, 4'd7},  // R7 reset request stored
    {1'b1, 4'd4, 4'd5, 4'd8,  4'd1, 4'd9},  // R9 freeze plus unfreeze
    {1'b1, 4'd8, 4'd1, 4'd4,  4'd2, 4'd9},  // R9 control still 2
    {1'b1, 4'd4, 4'd0, 4'd4,  4'd0, 4'd8},  // R8 write 0 first
    {1'b1, 4'd4, 4'd4, 4'd0,  4'd2, 4'd8}   // R8 unfreeze
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    up_valid = 1'b0; dn_ready = 1'b0; dn_done = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R2 reset state
    rd(4'd4, r); check("R2 ctrl", r, 0);
    rd(4'd8, r); check("R2 capture", r, 0);
    check("R2 freeze", {31'd0, region_freeze}, 0);
    check("R2 reset", {31'd0, region_reset}, 0);

    // R7 reset request while running has no effect
    wr(4'd4, 32'd2);
    check("R7 reset low running", {31'd0, region_reset}, 0);
    wr(4'd4, 32'd0);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][20]) wr(VEC[i][19:16], {28'd0, VEC[i][15:12]});
      cyc(3);
      rd(VEC[i][11:8], r);
      checks++;
      if (r !== {28'd0, VEC[i][7:4]}) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=%0h expected=%0h", VEC[i][3:0], i, r, VEC[i][7:4]);
      end
      if (i == 7) check("R7 reset high frozen", {31'd0, region_reset}, 1);
    end
    check("R8 reset released", {31'd0, region_reset}, 0);
    check("R8 freeze released", {31'd0, region_freeze}, 0);

    // R11 pass-through while running
    @(negedge clk); up_valid = 1'b1; dn_ready = 1'b0;
    #1 check("R11 dn_valid", {31'd0, dn_valid}, 1);
    check("R11 up_ready follows", {31'd0, up_ready}, 0);
    dn_ready = 1'b1;
    #1 check("R11 up_ready", {31'd0, up_ready}, 1);
    check("R11 no error", {31'd0, up_err}, 0);

    // R4 fill to the limit: four accepts
    cyc(4);
    #1 check("R4 full blocks", {31'd0, up_ready}, 0);
    check("R4 full no dn_valid", {31'd0, dn_valid}, 0);
    up_valid = 1'b0;
    dn_done = 1'b1;
    cyc(4);
    dn_done = 1'b0;

    // R3 drain with two in flight
    up_valid = 1'b1;
    cyc(2);
    up_valid = 1'b0;
    wr(4'd4, 32'd1);
    cyc(2);
    rd(4'd0, r); check("R5 draining status", r, 0);
    up_valid = 1'b1;
    #1 check("R3 no accept", {31'd0, up_ready}, 0);
    check("R3 no dn_valid", {31'd0, dn_valid}, 0);
    check("R3 no error draining", {31'd0, up_err}, 0);
    up_valid = 1'b0;
    dn_done = 1'b1;
    cyc(1);
    rd(4'd0, r); check("R3 still draining", r, 0);
    cyc(1);
    dn_done = 1'b0;
    cyc(2);
    rd(4'd0, r); check("R3 freeze done", r, 1);

    // R6 refusal while frozen
    up_valid = 1'b1;
    #1 check("R6 refuse ready", {31'd0, up_ready}, 1);
    check("R6 refuse err", {31'd0, up_err}, 1);
    check("R6 no dn_valid", {31'd0, dn_valid}, 0);
    cyc(1);
    up_valid = 1'b0;
    rd(4'd8, r); check("R6 capture bit", r, 2);
    wr(4'd8, 32'd1);
    rd(4'd8, r); check("R10 cleared", r, 0);

    // R10 set wins over clear in the same cycle
    @(negedge clk);
    up_valid = 1'b1; reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 32'd1;
    @(negedge clk);
    up_valid = 1'b0; reg_wr = 1'b0;
    rd(4'd8, r); check("R10 set wins", r, 2);

    // R8 leave frozen state
    wr(4'd4, 32'd4);
    rd(4'd0, r); check("R8 status", r, 2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule